// File: doc/BRIEF.md
# Memory Test Pattern Generator and Read-Back Checker

This block supplies the data word to be written at every burst address and beat of a memory under test, and grades the words read back against the same pattern. The pattern depends only on a pattern code, the current test iteration, the burst address and the beat number. The checker therefore rebuilds the expected word from the read-side address and beat, and keeps no copy of what was written.

Four patterns are offered: solid zeros, solid ones, a checkerboard and a moving sequence. The checkerboard inverts between test iterations and between neighbouring burst accesses. The moving sequence steps through fourteen words, each with as many ones as zeros. Every read beat yields a registered error mask, which is the XOR of the expected and received words. Flags derived from the mask tell a single-bit error from a multi-bit one. At the end of each burst in the moving pattern, the checker reports whether the whole burst arrived displaced by a fixed number of beats.

Top module: `mem_pattern_engine`

## Requirements
- R1: The pattern code selects the write word: 2'b00 gives all zeros, 2'b01 gives all ones, 2'b10 gives the checkerboard and 2'b11 gives the moving sequence. `wr_data` depends combinationally on `pat_sel`, `iter_idx`, `wr_addr` and `wr_beat`.
- R2: The checkerboard polarity is `iter_idx[0] ^ addr[0]`. With polarity 0 the word has every odd-numbered bit set (0xAAAAAAAA at 32 bits). With polarity 1 it is the complement. Stepping the iteration by one therefore inverts the word.
- R3: Consecutive burst accesses, meaning burst addresses that differ in bit 0, receive inverted checkerboard words within the same iteration.
- R4: Moving word k, for k from 0 to 13, is a word whose low DATA_W/2 bits are set, rotated left by k. Every moving word holds exactly DATA_W/2 ones.
- R5: The moving index is (addr mod 14 + iter mod 14 + beat) mod 14. It therefore advances by one per beat and wraps after 14 steps, so fourteen consecutive addresses give fourteen distinct words and address 14 repeats address 0.
- R6: One cycle after a beat with `rd_valid` high, `err_valid` is 1 and `err_mask` equals the expected word XOR `rd_data`. One cycle after `rd_valid` is low, `err_valid` is 0 and `err_mask` is 0.
- R7: `err_any` is 1 when the registered mask is non-zero. `err_multi` is 1 when the mask has more than one bit set.
- R8: Read beats of a burst arrive in order from 0 to BURST_LEN-1. One cycle after the last beat, `shift_valid` pulses. In the moving pattern, `shift_det` is 1 exactly when the burst was not fully correct and every beat b equals moving word (index_b + s) for one common nonzero s with |s| < BURST_LEN.
- R9: In the zeros, ones and checkerboard patterns `shift_det` stays 0, whatever data arrives.
- R10: While reset is held and straight after it, `err_valid`, `err_mask`, `err_any`, `err_multi`, `shift_valid` and `shift_det` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_sel | input | 2 | Pattern code |
| iter_idx | input | ITER_W | Test iteration number |
| wr_addr | input | ADDR_W | Burst address of the write |
| wr_beat | input | BEAT_W | Beat within the write burst |
| wr_data | output | DATA_W | Pattern word to write |
| rd_valid | input | 1 | A read beat is present |
| rd_addr | input | ADDR_W | Burst address of the read |
| rd_beat | input | BEAT_W | Beat within the read burst |
| rd_data | input | DATA_W | Word read back |
| err_valid | output | 1 | Check result present |
| err_mask | output | DATA_W | Expected XOR received |
| err_any | output | 1 | At least one bit wrong |
| err_multi | output | 1 | More than one bit wrong |
| shift_valid | output | 1 | Burst verdict present |
| shift_det | output | 1 | Burst displaced by whole beats |

## Verification
The write side is tried with each pattern code, with both iteration parities and both address parities, and with a sweep of fourteen addresses followed by the wrap. Together these separate the polarity rule, the rotation amount and the modulo arithmetic. The read side first gets clean beats, then beats with one and with three flipped bits, which tells the mask from the single-bit and multi-bit flags. Bursts displaced forward by one beat and backward by two beats, including one that wraps the sequence, must be flagged as shifted. A correct burst, a burst with a shift broken in one beat, and displaced data under the checkerboard code must not be flagged, which separates a shift from ordinary corruption.

// File: rtl/mem_pattern_engine.sv
module mem_pattern_engine #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 16,
  parameter int ITER_W    = 16,
  parameter int BURST_LEN = 4,
  parameter int BEAT_W    = $clog2(BURST_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pat_sel,
  input  logic [ITER_W-1:0] iter_idx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BEAT_W-1:0] wr_beat,
  output logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [BEAT_W-1:0] rd_beat,
  input  logic [DATA_W-1:0] rd_data,
  output logic              err_valid,
  output logic [DATA_W-1:0] err_mask,
  output logic              err_any,
  output logic              err_multi,
  output logic              shift_valid,
  output logic              shift_det
);

  localparam int SEQ_LEN = 14;
  localparam int NOFF    = 2 * BURST_LEN - 1;
  localparam int CENTER  = BURST_LEN - 1;
  localparam logic [1:0] P_ZERO = 2'b00, P_ONE = 2'b01, P_CHK = 2'b10, P_MOV = 2'b11;
  localparam logic [DATA_W-1:0] HALF_ONES = {{(DATA_W/2){1'b0}}, {(DATA_W/2){1'b1}}};
  localparam logic [DATA_W-1:0] CHK_BASE  = {(DATA_W/2){2'b10}};
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);
  localparam logic [NOFF-1:0]   CENTER_BIT = NOFF'(1) << CENTER;

  function automatic logic [3:0] seq_pos(input logic [ADDR_W-1:0] a,
                                         input logic [ITER_W-1:0] it,
                                         input logic [BEAT_W-1:0] b,
                                         input int                off);
    int s;
    s = int'(32'(a) % 32'd14) + int'(32'(it) % 32'd14) + int'(32'(b)) + SEQ_LEN + off;
    return 4'(s % SEQ_LEN);
  endfunction

  function automatic logic [DATA_W-1:0] moving_word(input logic [3:0] k);
    return (HALF_ONES << k) | (HALF_ONES >> (DATA_W - int'(k)));
  endfunction

  function automatic logic [DATA_W-1:0] pattern_word(input logic [1:0]        p,
                                                     input logic [ADDR_W-1:0] a,
                                                     input logic [ITER_W-1:0] it,
                                                     input logic [BEAT_W-1:0] b);
    logic [DATA_W-1:0] w;
    case (p)
      P_ZERO:  w = '0;
      P_ONE:   w = '1;
      P_CHK:   w = CHK_BASE ^ {DATA_W{it[0] ^ a[0]}};
      default: w = moving_word(seq_pos(a, it, b, 0));
    endcase
    return w;
  endfunction

  assign wr_data = pattern_word(pat_sel, wr_addr, iter_idx, wr_beat);

  logic [DATA_W-1:0] rd_exp;
  logic [DATA_W-1:0] diff;
  logic [NOFF-1:0]   hit, acc, acc_next;

  assign rd_exp = pattern_word(pat_sel, rd_addr, iter_idx, rd_beat);
  assign diff   = rd_exp ^ rd_data;

  for (genvar g = 0; g < NOFF; g++) begin : g_off
    assign hit[g] = rd_data == moving_word(seq_pos(rd_addr, iter_idx, rd_beat, g - CENTER));
  end

  assign acc_next = ((rd_beat == '0) ? {NOFF{1'b1}} : acc) & hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_valid   <= 1'b0;
      err_mask    <= '0;
      err_any     <= 1'b0;
      err_multi   <= 1'b0;
      shift_valid <= 1'b0;
      shift_det   <= 1'b0;
      acc         <= '0;
    end else begin
      err_valid   <= rd_valid;
      err_mask    <= rd_valid ? diff : '0;
      err_any     <= rd_valid && (diff != '0);
      err_multi   <= rd_valid && ($countones(diff) > 1);
      shift_valid <= rd_valid && (rd_beat == LAST_BEAT);
      shift_det   <= rd_valid && (rd_beat == LAST_BEAT) && (pat_sel == P_MOV)
                     && !acc_next[CENTER] && ((acc_next & ~CENTER_BIT) != '0);
      if (rd_valid) acc <= acc_next;
    end
  end

  a_r6_result_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> err_valid);
  a_r6_idle_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> (err_mask == '0 && !err_valid));
  a_r7_multi_needs_any: assert property (@(posedge clk) disable iff (!rst_n)
    err_multi |-> (err_any && $countones(err_mask) > 1));
  a_r4_moving_balanced: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_sel == P_MOV) |-> ($countones(wr_data) == DATA_W/2));
  a_r2_checker_balanced: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_sel == P_CHK) |-> ($countones(wr_data) == DATA_W/2));
  a_r8_verdict_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    shift_valid |-> $past(rd_valid && rd_beat == LAST_BEAT));
  a_r9_shift_only_moving: assert property (@(posedge clk) disable iff (!rst_n)
    shift_det |-> (shift_valid && $past(pat_sel) == P_MOV));

endmodule

// File: tb/mem_pattern_engine_bench.sv
`timescale 1ns/1ps
module mem_pattern_engine_bench;
  localparam int DW = 32, AW = 16, IW = 16, BL = 4, BW = 2;

  logic clk = 0, rst_n = 0;
  logic [1:0] pat_sel = 0;
  logic [IW-1:0] iter_idx = 0;
  logic [AW-1:0] wr_addr = 0, rd_addr = 0;
  logic [BW-1:0] wr_beat = 0, rd_beat = 0;
  logic [DW-1:0] wr_data, rd_data = 0, err_mask;
  logic rd_valid = 0, err_valid, err_any, err_multi, shift_valid, shift_det;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  mem_pattern_engine #(.DATA_W(DW), .ADDR_W(AW), .ITER_W(IW), .BURST_LEN(BL)) u_mem_pattern_engine (
    .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel), .iter_idx(iter_idx),
    .wr_addr(wr_addr), .wr_beat(wr_beat), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_beat(rd_beat), .rd_data(rd_data),
    .err_valid(err_valid), .err_mask(err_mask), .err_any(err_any), .err_multi(err_multi),
    .shift_valid(shift_valid), .shift_det(shift_det));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int ref_idx(input int a, input int it, input int b);
    return ((a % 14) + (it % 14) + b + 28) % 14;
  endfunction

  function automatic logic [DW-1:0] ref_mov(input int k);
    logic [DW-1:0] w;
    w = 32'h0000_FFFF;
    for (int i = 0; i < k; i++) w = {w[DW-2:0], w[DW-1]};
    return w;
  endfunction

  function automatic logic [DW-1:0] ref_chk(input int pol);
    return (pol % 2 == 0) ? 32'hAAAA_AAAA : 32'h5555_5555;
  endfunction

  task automatic set_wr(input logic [1:0] p, input int it, input int a, input int b);
    pat_sel = p; iter_idx = IW'(it); wr_addr = AW'(a); wr_beat = BW'(b);
    #1;
  endtask

  task automatic rd_one(input int a, input int b, input logic [DW-1:0] d);
    rd_valid = 1; rd_addr = AW'(a); rd_beat = BW'(b); rd_data = d;
    @(posedge clk); #1;
  endtask

  task automatic rd_idle;
    rd_valid = 0;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    chk("R10 err_valid", 32'(err_valid), 0);
    chk("R10 err_mask", err_mask, 0);
    chk("R10 err_flags", 32'({err_any, err_multi}), 0);
    chk("R10 shift", 32'({shift_valid, shift_det}), 0);
  endtask

  task automatic t_fixed;
    set_wr(2'b00, 5, 9, 3); chk("R1 zeros", wr_data, 32'h0);
    set_wr(2'b01, 5, 9, 3); chk("R1 ones", wr_data, 32'hFFFF_FFFF);
    set_wr(2'b10, 0, 0, 0); chk("R1 checker code", wr_data, 32'hAAAA_AAAA);
    set_wr(2'b11, 0, 0, 0); chk("R1 moving code", wr_data, 32'h0000_FFFF);
  endtask

  task automatic t_checker;
    set_wr(2'b10, 0, 4, 1); chk("R2 iter even", wr_data, ref_chk(0));
    set_wr(2'b10, 1, 4, 1); chk("R2 iter odd inverts", wr_data, ref_chk(1));
    set_wr(2'b10, 2, 5, 2); chk("R3 next burst inverts", wr_data, ref_chk(1));
    set_wr(2'b10, 3, 5, 0); chk("R3 both flips cancel", wr_data, ref_chk(0));
  endtask

  task automatic t_moving;
    logic [DW-1:0] seen [14];
    for (int a = 0; a < 14; a++) begin
      set_wr(2'b11, 0, a, 0);
      seen[a] = wr_data;
      chk("R4 moving word", wr_data, ref_mov(a));
      chk("R4 balanced", 32'($countones(wr_data)), 16);
    end
    for (int i = 0; i < 14; i++)
      for (int j = i + 1; j < 14; j++)
        if (seen[i] == seen[j]) chk("R5 distinct", seen[j], ~seen[i]);
    set_wr(2'b11, 0, 14, 0); chk("R5 wrap", wr_data, seen[0]);
    set_wr(2'b11, 3, 12, 2); chk("R5 beat+iter index", wr_data, ref_mov(ref_idx(12, 3, 2)));
  endtask

  task automatic t_readback;
    logic [DW-1:0] e;
    pat_sel = 2'b10; iter_idx = 1;
    rd_one(2, 0, ref_chk(1));
    chk("R6 valid", 32'(err_valid), 1); chk("R6 clean mask", err_mask, 0);
    chk("R7 clean flags", 32'({err_any, err_multi}), 0);
    e = ref_chk(0);
    rd_one(3, 1, e ^ 32'h0000_0100);
    chk("R6 single mask", err_mask, 32'h0000_0100);
    chk("R7 single flags", 32'({err_any, err_multi}), 32'b10);
    pat_sel = 2'b11;
    e = ref_mov(ref_idx(7, 1, 2));
    rd_one(7, 2, e ^ 32'h8000_0011);
    chk("R6 multi mask", err_mask, 32'h8000_0011);
    chk("R7 multi flags", 32'({err_any, err_multi}), 32'b11);
    rd_data = 32'hDEAD_BEEF;
    rd_idle;
    chk("R6 idle valid", 32'(err_valid), 0); chk("R6 idle mask", err_mask, 0);
  endtask

  task automatic burst(input logic [1:0] p, input int a, input int it, input int s,
                       input int bad_beat, input logic exp_det, input string req);
    pat_sel = p; iter_idx = IW'(it);
    for (int b = 0; b < BL; b++) begin
      logic [DW-1:0] d;
      d = ref_mov(ref_idx(a, it, b + s));
      if (b == bad_beat) d = d ^ 32'h0000_0004;
      rd_one(a, b, d);
      if (b < BL - 1) chk({req, " no early verdict"}, 32'(shift_valid), 0);
    end
    chk({req, " verdict"}, 32'(shift_valid), 1);
    chk({req, " shift"}, 32'(shift_det), 32'(exp_det));
    rd_idle;
  endtask

  task automatic t_shift;
    burst(2'b11, 5, 3, 0, -1, 1'b0, "R8 correct burst");
    burst(2'b11, 5, 3, 1, -1, 1'b1, "R8 shift +1");
    burst(2'b11, 12, 1, -2, -1, 1'b1, "R8 shift -2 wrap");
    burst(2'b11, 20, 2, 1, 2, 1'b0, "R8 broken shift");
    burst(2'b10, 5, 3, 1, -1, 1'b0, "R9 checker no shift");
    burst(2'b00, 6, 0, 1, -1, 1'b0, "R9 zeros no shift");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset;
    rst_n = 1;
    @(posedge clk); #1;
    t_reset;
    t_fixed;
    t_checker;
    t_moving;
    t_readback;
    t_shift;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule